// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces two memory addresses per clock cycle from a shared file of pointer register sets. There are four sets. Each holds an index, a length, a base and a step, and all are 32 bits wide. Each of the two access ports names a set and an update mode. The port's address is the set's current index, or the index plus its step in the offset mode. In the same cycle the selected index is post-modified, so the next access to that set sees the new value.

A nonzero length makes the set a circular buffer over the window from the base up to, but not including, base plus length. An index that steps past the top of the window drops back by the length. An index that steps below the base rises by the length. A length of zero gives plain linear stepping. A reverse-carry step mode walks a power-of-two buffer in bit-reversed order, as an FFT needs. A single write port loads any register of any set.

Top module: `cbuf_agu`

## Requirements
- R1: Every port address is combinational from the registers and appears in the same cycle as the request. Except in offset mode (code 4), the address is the selected set's index before that cycle's update. The two ports are served independently in the same cycle.
- R2: With length 0, step-up (code 1) and step-down (code 2) add or subtract the step register modulo 2^32, with no wrap.
- R3: With nonzero length, step-up adds the step. If the result's offset from the base is at or beyond the length, the length is subtracted. This assumes the step is smaller than the length.
- R4: With nonzero length, step-down subtracts the step. If the index's offset from the base is smaller than the step, the length is added.
- R5: Immediate mode (code 3) post-modifies the index by the port's signed 32-bit immediate, with the wrap rules of R3 and R4.
- R6: Offset mode (code 4) outputs index plus step (modulo 2^32) and leaves the index unchanged. Plain mode (code 0) outputs the index and leaves it unchanged.
- R7: Reverse-carry mode (code 5) outputs the index and then replaces it with index plus step. The carry in this addition runs from bit 31 toward bit 0 and is lost out of bit 0.
- R8: When both ports update the same set in one cycle, port 0's result is stored and port 1's is discarded.
- R9: The write port selects a register with kind 0 (index), 1 (length), 2 (base) or 3 (step) and a set number. The new value is visible from the next cycle. A write to an index takes priority over any post-modify of that index in the same cycle.
- R10: The four sets are independent. An access or a write to one set leaves the registers of the other sets unchanged.
- R11: After reset every register of every set is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind: 0 index, 1 length, 2 base, 3 step |
| wr_set | input | 2 | Set written |
| wr_data | input | 32 | Write value |
| acc_en | input | 2 | Access request, one bit per port |
| acc_set | input | 2x2 | Set selected by each port |
| acc_mode | input | 2x3 | Update mode for each port |
| acc_imm | input | 2x32 | Signed immediate for each port |
| acc_addr | output | 2x32 | Address from each port |

## Verification
Linear stepping in both directions is run with a zero length. This separates a plain adder from the wrap logic. Circular runs cross the top of the window and the bottom separately, with both the step register and signed immediates, so an error in either bound or in the sign handling shows up on its own. An eight-point reverse-carry walk must give the order 0,4,2,6,1,5,3,7 above a nonzero upper part, which a normal carry cannot produce. Concurrent accesses to different sets and to the same set, and a write that collides with an update, check port independence, port 0 priority and write priority.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
  localparam int unsigned AW = 32;

  typedef enum logic [2:0] {
    AM_PLAIN  = 3'd0,
    AM_UP     = 3'd1,
    AM_DOWN   = 3'd2,
    AM_IMM    = 3'd3,
    AM_OFFSET = 3'd4,
    AM_RCARRY = 3'd5
  } amode_e;

  typedef enum logic [1:0] {
    RK_INDEX = 2'd0,
    RK_LEN   = 2'd1,
    RK_BASE  = 2'd2,
    RK_STEP  = 2'd3
  } rkind_e;

  typedef struct packed {
    logic [AW-1:0] val;
    logic          hi;
    logic          lo;
  } step_t;

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] x);
    logic [AW-1:0] r;
    for (int k = 0; k < AW; k++) r[k] = x[AW-1-k];
    return r;
  endfunction

  // addition whose carry travels toward the least significant bit
  function automatic logic [AW-1:0] rcarry_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return flip(flip(a) + flip(b));
  endfunction

  // signed post-modify confined to [base, base+len) when len is nonzero
  function automatic step_t circ_step(input logic [AW-1:0] idx, input logic [AW-1:0] delta,
                                      input logic [AW-1:0] base, input logic [AW-1:0] len);
    step_t         s;
    logic [AW-1:0] off;
    logic [AW-1:0] mag;
    s.val = idx + delta;
    s.hi  = 1'b0;
    s.lo  = 1'b0;
    if (len != '0) begin
      off = idx - base;
      if (delta[AW-1]) begin
        mag = -delta;
        if (off < mag) begin
          s.val = s.val + len;
          s.lo  = 1'b1;
        end
      end else if (off + delta >= len) begin
        s.val = s.val - len;
        s.hi  = 1'b1;
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/cbuf_addr_gen.sv
module cbuf_addr_gen
  import cbuf_pkg::*;
(
  input  logic          en,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] imm,
  input  logic [AW-1:0] ival,
  input  logic [AW-1:0] lval,
  input  logic [AW-1:0] bval,
  input  logic [AW-1:0] mval,
  output logic [AW-1:0] addr,
  output logic          upd,
  output logic [AW-1:0] nxt,
  output logic          wrap_hi,
  output logic          wrap_lo
);
  step_t st;

  always_comb begin
    addr = ival;
    upd  = 1'b0;
    st   = '{val: ival, hi: 1'b0, lo: 1'b0};
    unique case (amode_e'(mode))
      AM_UP:     begin st = circ_step(ival, mval, bval, lval);  upd = en; end
      AM_DOWN:   begin st = circ_step(ival, -mval, bval, lval); upd = en; end
      AM_IMM:    begin st = circ_step(ival, imm, bval, lval);   upd = en; end
      AM_RCARRY: begin st.val = rcarry_add(ival, mval);         upd = en; end
      AM_OFFSET: addr = ival + mval;
      default:   ;
    endcase
    nxt     = st.val;
    wrap_hi = en & st.hi;
    wrap_lo = en & st.lo;
  end
endmodule

// File: rtl/cbuf_regs.sv
module cbuf_regs
  import cbuf_pkg::*;
#(
  parameter int unsigned NSETS = 4,
  parameter int unsigned NGEN  = 2,
  localparam int unsigned SETW = $clog2(NSETS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_kind,
  input  logic [SETW-1:0]            wr_set,
  input  logic [AW-1:0]              wr_data,
  input  logic [NGEN-1:0]            upd,
  input  logic [NGEN-1:0][SETW-1:0]  upd_set,
  input  logic [NGEN-1:0][AW-1:0]    upd_val,
  output logic [NSETS-1:0][AW-1:0]   ireg,
  output logic [NSETS-1:0][AW-1:0]   lreg,
  output logic [NSETS-1:0][AW-1:0]   breg,
  output logic [NSETS-1:0][AW-1:0]   mreg
);
  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic          hit;
    logic [AW-1:0] pick;
    logic          wsel;

    assign wsel = wr_en && (wr_set == SETW'(s));

    // lowest-numbered port is visited last, so it wins
    always_comb begin
      hit  = 1'b0;
      pick = ireg[s];
      for (int g = NGEN - 1; g >= 0; g--) begin
        if (upd[g] && upd_set[g] == SETW'(s)) begin
          hit  = 1'b1;
          pick = upd_val[g];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ireg[s] <= '0;
        lreg[s] <= '0;
        breg[s] <= '0;
        mreg[s] <= '0;
      end else begin
        if (wsel && wr_kind == RK_INDEX) ireg[s] <= wr_data;
        else if (hit)                    ireg[s] <= pick;
        if (wsel && wr_kind == RK_LEN)   lreg[s] <= wr_data;
        if (wsel && wr_kind == RK_BASE)  breg[s] <= wr_data;
        if (wsel && wr_kind == RK_STEP)  mreg[s] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/cbuf_agu.sv
module cbuf_agu
  import cbuf_pkg::*;
#(
  parameter int unsigned NSETS = 4,
  parameter int unsigned NGEN  = 2,
  localparam int unsigned SETW = $clog2(NSETS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_kind,
  input  logic [SETW-1:0]           wr_set,
  input  logic [AW-1:0]             wr_data,
  input  logic [NGEN-1:0]           acc_en,
  input  logic [NGEN-1:0][SETW-1:0] acc_set,
  input  logic [NGEN-1:0][2:0]      acc_mode,
  input  logic [NGEN-1:0][AW-1:0]   acc_imm,
  output logic [NGEN-1:0][AW-1:0]   acc_addr
);
  logic [NSETS-1:0][AW-1:0] ireg, lreg, breg, mreg;
  logic [NGEN-1:0]          upd, wrap_hi, wrap_lo;
  logic [NGEN-1:0][AW-1:0]  nxt;

  cbuf_regs #(.NSETS(NSETS), .NGEN(NGEN)) u_regs (
    .clk, .rst_n, .wr_en, .wr_kind, .wr_set, .wr_data,
    .upd, .upd_set(acc_set), .upd_val(nxt),
    .ireg, .lreg, .breg, .mreg
  );

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    cbuf_addr_gen u_gen (
      .en(acc_en[g]), .mode(acc_mode[g]), .imm(acc_imm[g]),
      .ival(ireg[acc_set[g]]), .lval(lreg[acc_set[g]]),
      .bval(breg[acc_set[g]]), .mval(mreg[acc_set[g]]),
      .addr(acc_addr[g]), .upd(upd[g]), .nxt(nxt[g]),
      .wrap_hi(wrap_hi[g]), .wrap_lo(wrap_lo[g])
    );
  end

  // named events for the checks below
  logic same_set_clash;
  logic wr_idx0;
  logic p1_on_p0_set;
  assign same_set_clash = upd[0] && upd[1] && acc_set[0] == acc_set[1];
  assign wr_idx0        = wr_en && wr_kind == RK_INDEX && wr_set == acc_set[0];
  assign p1_on_p0_set   = upd[1] && acc_set[1] == acc_set[0];

  AST_ADDR_PRE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en[0] && acc_mode[0] != AM_OFFSET |-> acc_addr[0] == ireg[acc_set[0]]); // R1
  AST_UP_STAYS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en[0] && acc_mode[0] == AM_UP && lreg[acc_set[0]] != '0 &&
    (ireg[acc_set[0]] - breg[acc_set[0]]) < lreg[acc_set[0]] && mreg[acc_set[0]] < lreg[acc_set[0]]
    |-> (nxt[0] - breg[acc_set[0]]) < lreg[acc_set[0]]); // R3
  AST_DOWN_STAYS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en[0] && acc_mode[0] == AM_DOWN && lreg[acc_set[0]] != '0 &&
    (ireg[acc_set[0]] - breg[acc_set[0]]) < lreg[acc_set[0]] && mreg[acc_set[0]] < lreg[acc_set[0]]
    |-> (nxt[0] - breg[acc_set[0]]) < lreg[acc_set[0]]); // R4
  AST_NO_WRAP_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en[0] && lreg[acc_set[0]] == '0 |-> !wrap_hi[0] && !wrap_lo[0]); // R2
  AST_OFFSET_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en[0] && acc_mode[0] == AM_OFFSET && !p1_on_p0_set && !wr_idx0
    |=> ireg[$past(acc_set[0])] == $past(ireg[acc_set[0]])); // R6
  AST_PORT0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    same_set_clash && !wr_idx0 |=> ireg[$past(acc_set[0])] == $past(nxt[0])); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_kind == RK_INDEX |=> ireg[$past(wr_set)] == $past(wr_data)); // R9
endmodule

// File: tb/tb_cbuf_agu.sv
module tb_cbuf_agu;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_kind = '0;
  logic [1:0]       wr_set = '0;
  logic [31:0]      wr_data = '0;
  logic [1:0]       acc_en = '0;
  logic [1:0][1:0]  acc_set = '0;
  logic [1:0][2:0]  acc_mode = '0;
  logic [1:0][31:0] acc_imm = '0;
  logic [1:0][31:0] acc_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cbuf_agu dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input int s, input int kind, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_set = 2'(s); wr_kind = 2'(kind); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic setup(input int s, input logic [31:0] i, input logic [31:0] l,
                       input logic [31:0] b, input logic [31:0] m);
    wreg(s, 0, i); wreg(s, 1, l); wreg(s, 2, b); wreg(s, 3, m);
  endtask

  // one access on port g, address checked before the edge
  task automatic acc1(input int g, input int s, input int mode, input logic [31:0] imm,
                      input logic [31:0] exp, input string req);
    @(negedge clk);
    acc_en[g] = 1'b1; acc_set[g] = 2'(s); acc_mode[g] = 3'(mode); acc_imm[g] = imm;
    #1 check(req, acc_addr[g], exp);
    @(posedge clk); #1;
    acc_en = '0;
  endtask

  // read an index back through a plain access on port 1
  task automatic peek(input int s, input logic [31:0] exp, input string req);
    @(negedge clk);
    acc_en[1] = 1'b1; acc_set[1] = 2'(s); acc_mode[1] = 3'd0;
    #1 check(req, acc_addr[1], exp);
    acc_en[1] = 1'b0;
  endtask

  function automatic logic [31:0] rev_add(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic [1:0]  t;
    logic        c = 1'b0;
    for (int k = 31; k >= 0; k--) begin
      t = 2'(a[k]) + 2'(b[k]) + 2'(c);
      r[k] = t[0];
      c = t[1];
    end
    return r;
  endfunction

  task automatic t_reset();
    for (int s = 0; s < 4; s++) peek(s, 32'h0, "R11 index");
    acc1(0, 3, 4, 0, 32'h0, "R11 step/offset zero");
  endtask

  task automatic t_linear();
    setup(0, 32'h0000_1000, 0, 32'h0000_1000, 4);
    acc1(0, 0, 1, 0, 32'h1000, "R1 up addr");
    peek(0, 32'h1004, "R2 linear up");
    acc1(0, 0, 2, 0, 32'h1004, "R1 down addr");
    acc1(0, 0, 2, 0, 32'h1000, "R2 down addr");
    peek(0, 32'h0FFC, "R2 linear down past base");
    wreg(0, 0, 32'hFFFF_FFFC);
    acc1(0, 0, 1, 0, 32'hFFFF_FFFC, "R2 top addr");
    peek(0, 32'h0, "R2 modulo wrap");
  endtask

  task automatic t_circular();
    setup(1, 32'h0000_020C, 32'h10, 32'h0000_0200, 4);
    acc1(0, 1, 1, 0, 32'h20C, "R3 addr");
    peek(1, 32'h200, "R3 wrap top");
    acc1(0, 1, 2, 0, 32'h200, "R4 addr");
    peek(1, 32'h20C, "R4 wrap bottom");
    acc1(0, 1, 2, 0, 32'h20C, "R4 addr inside");
    peek(1, 32'h208, "R4 no wrap inside");
    acc1(1, 1, 3, 32'd12, 32'h208, "R5 addr");
    peek(1, 32'h204, "R5 positive imm wraps");
    acc1(0, 1, 3, -32'sd8, 32'h204, "R5 addr neg");
    peek(1, 32'h20C, "R5 negative imm wraps");
    acc1(0, 1, 3, 32'd2, 32'h20C, "R5 addr small");
    peek(1, 32'h20E, "R5 no wrap");
  endtask

  task automatic t_offset();
    setup(2, 32'h0000_3000, 0, 0, 32'h40);
    acc1(0, 2, 4, 0, 32'h3040, "R6 offset addr");
    peek(2, 32'h3000, "R6 offset no update");
    acc1(0, 2, 0, 0, 32'h3000, "R6 plain addr");
    peek(2, 32'h3000, "R6 plain no update");
  endtask

  task automatic t_rcarry();
    logic [31:0] model = 32'h0000_0100;
    logic [31:0] order [8] = '{32'h100, 32'h104, 32'h102, 32'h106,
                               32'h101, 32'h105, 32'h103, 32'h107};
    setup(3, 32'h0000_0100, 0, 0, 32'h4);
    for (int k = 0; k < 8; k++) begin
      check("R7 order table", model, order[k]);
      acc1(0, 3, 5, 0, model, "R7 rcarry addr");
      model = rev_add(model, 32'h4);
    end
    peek(3, 32'h100, "R7 return to start");
  endtask

  task automatic t_dual();
    wreg(0, 0, 32'h0000_5000);
    // different sets in the same cycle
    @(negedge clk);
    acc_en = 2'b11; acc_set[0] = 2'd0; acc_mode[0] = 3'd1;
    acc_set[1] = 2'd2; acc_mode[1] = 3'd4;
    #1 check("R1 port0 dual", acc_addr[0], 32'h5000);
    check("R1 port1 dual", acc_addr[1], 32'h3040);
    @(posedge clk); #1; acc_en = '0;
    peek(0, 32'h5004, "R10 set0 advanced");
    peek(2, 32'h3000, "R10 set2 untouched");
    peek(1, 32'h20E, "R10 set1 untouched");
    // both ports on set 0
    @(negedge clk);
    acc_en = 2'b11; acc_set[0] = 2'd0; acc_mode[0] = 3'd1;
    acc_set[1] = 2'd0; acc_mode[1] = 3'd2;
    #1 check("R8 port1 addr", acc_addr[1], 32'h5004);
    @(posedge clk); #1; acc_en = '0;
    peek(0, 32'h5008, "R8 port0 result kept");
    // write collides with update
    @(negedge clk);
    wr_en = 1'b1; wr_set = 2'd0; wr_kind = 2'd0; wr_data = 32'h0000_7000;
    acc_en[0] = 1'b1; acc_set[0] = 2'd0; acc_mode[0] = 3'd1;
    @(posedge clk); #1; wr_en = 1'b0; acc_en = '0;
    peek(0, 32'h7000, "R9 write beats update");
    wreg(2, 3, 32'h8);
    acc1(0, 2, 4, 0, 32'h3008, "R9 step write visible");
    peek(3, 32'h100, "R10 set3 untouched");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_linear();
    t_circular();
    t_offset();
    t_rcarry();
    t_dual();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule